// File: doc/BRIEF.md
# Debug scan transport

This block is the test access port of a debug transport. An external probe clocks it through `tck`, `tms` and `tdi` and reads `tdo`. Inside are the sixteen-state TAP controller, a 5-bit instruction register and three data paths: an identification word, a 32-bit transport control/status word, and a debug-access chain. The debug-access chain carries a request op, 32 data bits and an address in one shift path.

When an update of the debug-access chain ends in a read or write op, the block drives one request, for one TCK cycle, on a parallel bus towards a debug module. The module answers within that same cycle with read data and a success flag. The block keeps the whole updated word. It writes the result status into the op bits, so the next capture shifts that result back out. A failure is sticky. Once a failure is recorded, the block issues no further bus request until the probe writes the clear bit in the control/status word.

Top module: `dbg_scan_port`

## Requirements
- R1: The TAP state moves on each rising `tck` edge by the standard table. Five clocks with `tms`=1 reach Test-Logic-Reset from any state. Pause-DR can be entered and left in the middle of a DR scan without losing bits.
- R2: Entering Test-Logic-Reset, or asserting `rst_n` low, selects the ID instruction (0x01). Capture-IR loads 5'b00001.
- R3: The instruction codes are 0x01 for ID, 0x10 for control/status and 0x11 for debug access. Every other code, including 0x1C, selects a 1-bit bypass path that captures 0.
- R4: Scans shift least significant bit first. `tdi` enters at bit position length-1. `tdo` changes on the falling `tck` edge and is 0 outside Shift-IR and Shift-DR.
- R5: The ID path captures the 32-bit parameter `ID_VALUE`.
- R6: The control/status capture has these fields: bits 3:0 = 1, bits 9:4 = ABITS, bits 11:10 = current result status, bits 14:12 = `IDLE_HINT`. All other bits read 0.
- R7: The debug-access chain is ABITS+34 bits long: op in bits 1:0, data in bits 33:2, address in bits ABITS+33:34. Request ops are 0 no-op, 1 read, 2 write and 3 reserved. Status codes are 0 success and 2 failed.
- R8: A read op drives `req_valid`=1 with `req_write`=0 for the Update-DR cycle. On success the stored data becomes `rsp_rdata` and the status becomes 0.
- R9: A write op drives `req_valid`=1 with `req_write`=1 and the shifted address and data. On success the status becomes 0.
- R10: A request answered with `rsp_ok`=0 sets the status to 2. On a failed read the shifted data is kept. While the status is 2, an update of the debug-access chain issues no request and leaves the stored word unchanged.
- R11: An update of the control/status path with bit 16 set returns the status to 0. The other stored fields are kept.
- R12: A no-op issues no request and stores the shifted word with status 0. A reserved op issues no request and sets status 2.
- R13: After reset the debug-access chain captures all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| req_valid | output | 1 | Bus request, high for the Update-DR cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ABITS | Request address |
| req_wdata | output | 32 | Write data |
| rsp_rdata | input | 32 | Read data, valid while `req_valid` is high |
| rsp_ok | input | 1 | 1 = access succeeded |

## Verification
Two things can meet in a single update cycle: a new bus request and the failure state left by an earlier request. The bench fails a read at one address. It then scans a write straight after, before any clear, and scans a reserved op in a later step. It judges the result by the count of bus requests seen and by the next captured word, which must still carry the failed word unchanged. A sweep over every address chains each write and read with the capture of the previous result, so every update is checked in the scan that follows it.

// File: rtl/dbg_scan_port.sv
`timescale 1ns/1ps
module dbg_scan_port #(
  parameter int          ABITS     = 7,
  parameter logic [31:0] ID_VALUE  = 32'h2C5A_E1F3,
  parameter logic [2:0]  IDLE_HINT = 3'd5
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             req_valid,
  output logic             req_write,
  output logic [ABITS-1:0] req_addr,
  output logic [31:0]      req_wdata,
  input  logic [31:0]      rsp_rdata,
  input  logic             rsp_ok
);
  localparam int DW = ABITS + 34;
  localparam int LW = $clog2(DW + 1);

  localparam logic [4:0] IR_ID  = 5'h01;
  localparam logic [4:0] IR_CTL = 5'h10;
  localparam logic [4:0] IR_DMI = 5'h11;

  localparam logic [1:0] OP_NOP = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_WR  = 2'd2;
  localparam logic [1:0] ST_OK  = 2'd0;
  localparam logic [1:0] ST_ERR = 2'd2;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_t;

  tap_t            state_q, state_nxt;
  logic [4:0]      ir_q, ir_sh;
  logic [DW-1:0]   dr_q, dr_nxt, capt, dmi_q;
  logic [LW-1:0]   dr_len;
  logic [31:0]     ctl_word;
  logic            tdo_q;

  always_comb begin
    unique case (state_q)
      TLR:    state_nxt = tms ? TLR    : RTI;
      RTI:    state_nxt = tms ? SEL_DR : RTI;
      SEL_DR: state_nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR: state_nxt = tms ? EX1_DR : SHF_DR;
      SHF_DR: state_nxt = tms ? EX1_DR : SHF_DR;
      EX1_DR: state_nxt = tms ? UPD_DR : PAU_DR;
      PAU_DR: state_nxt = tms ? EX2_DR : PAU_DR;
      EX2_DR: state_nxt = tms ? UPD_DR : SHF_DR;
      UPD_DR: state_nxt = tms ? SEL_DR : RTI;
      SEL_IR: state_nxt = tms ? TLR    : CAP_IR;
      CAP_IR: state_nxt = tms ? EX1_IR : SHF_IR;
      SHF_IR: state_nxt = tms ? EX1_IR : SHF_IR;
      EX1_IR: state_nxt = tms ? UPD_IR : PAU_IR;
      PAU_IR: state_nxt = tms ? EX2_IR : PAU_IR;
      EX2_IR: state_nxt = tms ? UPD_IR : SHF_IR;
      UPD_IR: state_nxt = tms ? SEL_DR : RTI;
      default: state_nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) state_q <= TLR;
    else        state_q <= state_nxt;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                 ir_q <= IR_ID;
    else if (state_nxt == TLR)  ir_q <= IR_ID;
    else if (state_q == UPD_IR) ir_q <= ir_sh;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                 ir_sh <= 5'b00001;
    else if (state_q == CAP_IR) ir_sh <= 5'b00001;
    else if (state_q == SHF_IR) ir_sh <= {tdi, ir_sh[4:1]};

  assign ctl_word = {15'b0, 1'b0, 1'b0, IDLE_HINT, dmi_q[1:0], 6'(ABITS), 4'd1};

  always_comb begin
    case (ir_q)
      IR_ID:   begin capt = DW'(ID_VALUE); dr_len = LW'(32); end
      IR_CTL:  begin capt = DW'(ctl_word); dr_len = LW'(32); end
      IR_DMI:  begin capt = dmi_q;         dr_len = LW'(DW); end
      default: begin capt = '0;            dr_len = LW'(1);  end
    endcase
  end

  always_comb begin
    dr_nxt = dr_q >> 1;
    dr_nxt[dr_len - LW'(1)] = tdi;
  end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                 dr_q <= '0;
    else if (state_q == CAP_DR) dr_q <= capt;
    else if (state_q == SHF_DR) dr_q <= dr_nxt;

  wire       dmi_upd = (state_q == UPD_DR) && (ir_q == IR_DMI);
  wire       ctl_upd = (state_q == UPD_DR) && (ir_q == IR_CTL);
  wire       stuck   = (dmi_q[1:0] == ST_ERR);
  wire [1:0] op_in   = dr_q[1:0];

  assign req_valid = dmi_upd && !stuck && (op_in == OP_RD || op_in == OP_WR);
  assign req_write = (op_in == OP_WR);
  assign req_addr  = dr_q[DW-1:34];
  assign req_wdata = dr_q[33:2];

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) dmi_q <= '0;
    else if (dmi_upd && !stuck) begin
      case (op_in)
        OP_NOP:  dmi_q <= {dr_q[DW-1:2], ST_OK};
        OP_RD:   dmi_q <= {dr_q[DW-1:34], rsp_ok ? rsp_rdata : dr_q[33:2], rsp_ok ? ST_OK : ST_ERR};
        OP_WR:   dmi_q <= {dr_q[DW-1:2], rsp_ok ? ST_OK : ST_ERR};
        default: dmi_q <= {dr_q[DW-1:2], ST_ERR};
      endcase
    end else if (ctl_upd && dr_q[16]) dmi_q[1:0] <= ST_OK;

  always_ff @(negedge tck or negedge rst_n)
    if (!rst_n)                 tdo_q <= 1'b0;
    else if (state_q == SHF_IR) tdo_q <= ir_sh[0];
    else if (state_q == SHF_DR) tdo_q <= dr_q[0];
    else                        tdo_q <= 1'b0;

  assign tdo = tdo_q;

  assert_tlr_idcode_R2: assert property (@(posedge tck) disable iff (!rst_n)
    state_q == TLR |-> ir_q == IR_ID);
  assert_ir_change_R3: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(ir_q) |-> ($past(state_q) == UPD_IR || state_q == TLR));
  assert_tdo_idle_R4: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q != SHF_DR && state_q != SHF_IR) |-> tdo == 1'b0);
  assert_keep_addr_R7: assert property (@(posedge tck) disable iff (!rst_n)
    req_valid |=> dmi_q[DW-1:34] == $past(req_addr));
  assert_read_data_R8: assert property (@(posedge tck) disable iff (!rst_n)
    (req_valid && !req_write && rsp_ok) |=> (dmi_q[33:2] == $past(rsp_rdata) && dmi_q[1:0] == ST_OK));
  assert_write_ok_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (req_valid && req_write && rsp_ok) |=> dmi_q[1:0] == ST_OK);
  assert_fail_status_R10: assert property (@(posedge tck) disable iff (!rst_n)
    (req_valid && !rsp_ok) |=> dmi_q[1:0] == ST_ERR);
  assert_sticky_R10: assert property (@(posedge tck) disable iff (!rst_n)
    (dmi_q[1:0] == ST_ERR && !(state_q == UPD_DR && ir_q == IR_CTL)) |=> dmi_q[1:0] == ST_ERR);
  assert_no_req_stuck_R10: assert property (@(posedge tck) disable iff (!rst_n)
    dmi_q[1:0] == ST_ERR |-> !req_valid);
endmodule

// File: tb/dbg_scan_port_tb_top.sv
`timescale 1ns/1ps
module dbg_scan_port_tb_top;
  localparam int          AB   = 7;
  localparam int          DW   = AB + 34;
  localparam logic [31:0] IDV  = 32'h2C5A_E1F3;
  localparam logic [2:0]  IDLE = 3'd5;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, req_valid, req_write, rsp_ok;
  logic [AB-1:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;

  dbg_scan_port #(.ABITS(AB), .ID_VALUE(IDV), .IDLE_HINT(IDLE)) dut_i (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok));

  logic [31:0] mem [1<<AB];
  logic fail_en = 1'b0;
  logic [AB-1:0] fail_addr = '0;
  int req_cnt = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  assign rsp_rdata = mem[req_addr];
  assign rsp_ok    = !(fail_en && req_addr == fail_addr);

  always @(negedge tck)
    if (req_valid) begin
      req_cnt++;
      if (req_write && rsp_ok) mem[req_addr] = req_wdata;
    end

  function automatic logic [127:0] mk(int a, logic [31:0] d, logic [1:0] op);
    mk = '0;
    mk[1:0] = op;
    mk[33:2] = d;
    mk[DW-1:34] = a[AB-1:0];
  endfunction

  function automatic logic [31:0] pat(int a);
    return (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F00;
  endfunction

  function automatic logic [127:0] ctl(logic [1:0] st);
    return 128'(32'd1 | (32'(AB) << 4) | (32'(st) << 10) | (32'(IDLE) << 12));
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    tms = m; tdi = d; o = tdo;
    @(posedge tck);
  endtask

  task automatic shift_ir(input logic [4:0] code, output logic [4:0] cap);
    logic o;
    clk_bit(1, 0, o); clk_bit(1, 0, o); clk_bit(0, 0, o); clk_bit(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      clk_bit(i == 4, code[i], o);
      cap[i] = o;
    end
    clk_bit(1, 0, o); clk_bit(0, 0, o);
  endtask

  task automatic shift_dr(input int len, input logic [127:0] din, output logic [127:0] dout);
    logic o;
    dout = '0;
    clk_bit(1, 0, o); clk_bit(0, 0, o); clk_bit(0, 0, o);
    for (int i = 0; i < len; i++) begin
      clk_bit(i == len - 1, din[i], o);
      dout[i] = o;
    end
    clk_bit(1, 0, o); clk_bit(0, 0, o);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] out;
    logic [4:0] cap;
    logic o;
    int base;
    for (int i = 0; i < (1 << AB); i++) mem[i] = 32'h0;
    repeat (3) @(posedge tck);
    @(negedge tck); rst_n = 1'b1;
    #1; chk("R4 tdo low after reset", 128'(tdo), 128'(0));
    clk_bit(0, 0, o);
    shift_dr(32, 128'h0, out);
    chk("R5 R2 id after reset", out, 128'(IDV));

    shift_ir(5'h11, cap);
    chk("R2 capture-ir pattern", 128'(cap), 128'(5'b00001));
    base = req_cnt;
    shift_dr(DW, mk(5, 32'hDEAD_BEEF, 0), out);
    chk("R13 reset debug word", out, 128'h0);
    chk("R12 nop no request", 128'(req_cnt - base), 128'(0));

    base = req_cnt;
    for (int a = 0; a < (1 << AB); a++) begin
      shift_dr(DW, mk(a, pat(a), 2), out);
      if (a == 0) chk("R12 nop stores word", out, mk(5, 32'hDEAD_BEEF, 0));
      else        chk("R9 R7 write result", out, mk(a - 1, pat(a - 1), 0));
    end
    chk("R9 write request count", 128'(req_cnt - base), 128'(1 << AB));
    for (int a = 0; a < (1 << AB); a++) begin
      shift_dr(DW, mk(a, 32'h0, 1), out);
      if (a == 0) chk("R9 last write result", out, mk((1 << AB) - 1, pat((1 << AB) - 1), 0));
      else        chk("R8 read result", out, mk(a - 1, pat(a - 1), 0));
    end
    shift_dr(DW, mk(0, 32'h0, 0), out);
    chk("R8 last read result", out, mk((1 << AB) - 1, pat((1 << AB) - 1), 0));

    fail_en = 1'b1; fail_addr = 7'd3;
    base = req_cnt;
    shift_dr(DW, mk(3, 32'h1234_5678, 1), out);
    shift_dr(DW, mk(9, 32'hCAFE_0001, 2), out);
    chk("R10 failed read status", out, mk(3, 32'h1234_5678, 2));
    shift_dr(DW, mk(0, 32'h0, 0), out);
    chk("R10 word unchanged while failed", out, mk(3, 32'h1234_5678, 2));
    chk("R10 no request while failed", 128'(req_cnt - base), 128'(1));
    fail_en = 1'b0;

    shift_ir(5'h10, cap);
    shift_dr(32, 128'h0, out);
    chk("R6 control word failed", out, ctl(2));
    shift_dr(32, 128'(32'h0001_0000), out);
    chk("R6 control word before clear", out, ctl(2));
    shift_dr(32, 128'h0, out);
    chk("R11 control word cleared", out, ctl(0));
    shift_ir(5'h11, cap);
    shift_dr(DW, mk(0, 32'h0, 0), out);
    chk("R11 word kept status cleared", out, mk(3, 32'h1234_5678, 0));

    base = req_cnt;
    shift_dr(DW, mk(4, 32'h55, 3), out);
    shift_dr(DW, mk(0, 32'h0, 0), out);
    chk("R12 reserved op failed", out, mk(4, 32'h55, 2));
    chk("R12 reserved op no request", 128'(req_cnt - base), 128'(0));
    shift_ir(5'h10, cap);
    shift_dr(32, 128'(32'h0001_0000), out);
    shift_dr(32, 128'h0, out);
    chk("R11 clear after reserved", out, ctl(0));

    shift_ir(5'h1C, cap);
    shift_dr(8, 128'hB6, out);
    chk("R3 bypass for 0x1C", out, 128'h6C);
    shift_ir(5'h05, cap);
    shift_dr(8, 128'h5A, out);
    chk("R3 bypass for 0x05", out, 128'hB4);
    @(negedge tck); #1;
    chk("R4 tdo low in idle", 128'(tdo), 128'(0));

    shift_ir(5'h01, cap);
    out = '0;
    clk_bit(1, 0, o); clk_bit(0, 0, o); clk_bit(0, 0, o);
    for (int i = 0; i < 16; i++) begin clk_bit(i == 15, 0, o); out[i] = o; end
    clk_bit(0, 0, o); clk_bit(0, 0, o); clk_bit(1, 0, o); clk_bit(0, 0, o);
    for (int i = 16; i < 32; i++) begin clk_bit(i == 31, 0, o); out[i] = o; end
    clk_bit(1, 0, o); clk_bit(0, 0, o);
    chk("R1 scan across pause", out, 128'(IDV));

    shift_ir(5'h10, cap);
    clk_bit(1, 0, o); clk_bit(0, 0, o); clk_bit(0, 0, o);
    for (int i = 0; i < 5; i++) clk_bit(1, 0, o);
    clk_bit(0, 0, o);
    shift_dr(32, 128'h0, out);
    chk("R1 R2 five tms ones reset", out, 128'(IDV));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule